// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Unit

This block turns the one-byte addressing descriptor of an indexed instruction into a 16-bit effective address. The descriptor picks one of four base registers (or the program counter). It picks an offset source: a small constant embedded in the descriptor, an 8- or 16-bit constant taken from the instruction stream, or one of the accumulators. It can also ask for an automatic step of the base register, either before or after use. When the indirect bit is set, the computed address is used once more to read a 16-bit pointer, and that pointer becomes the result.

The sequencer of an instruction unit pulses `start` with the descriptor, the opcode and the register values, and holds them all until `done`. The unit pulls offset bytes through a byte handshake and the pointer through a word-read handshake. It returns the address, a write-back for the stepped base register, the advanced program counter and the number of extra cycles the mode costs. Descriptors with no defined meaning are flagged and produce no address.

Top module: `idx_ea_unit`

## Requirements
- R1: Descriptor bits 6-5 select the base register: 00 X, 01 Y, 10 U, 11 S. With bit 7 clear, bits 4-0 are a signed offset (-16..15) added to the base, costing 1 extra cycle, and `done` rises in the cycle after `start`.
- R2: With bit 7 set and low nibble 1000 or 1001, an 8- or 16-bit offset is fetched from the instruction stream, high byte first. It is sign-extended and added to the base, at a cost of 1 or 4 extra cycles.
- R3: Low nibble 0100 adds nothing (0 extra cycles). Low nibble 0110 adds sign-extended A and 0101 adds sign-extended B (1 cycle each). Low nibble 1011 adds the 16-bit value {A,B} (4 cycles).
- R4: Low nibble 1100 or 1101 adds an 8- or 16-bit fetched offset to the program counter advanced past the offset bytes, at a cost of 1 or 5 cycles. `pc_next` always equals `reg_pc` plus the number of bytes fetched.
- R5: Low nibble 0000 or 0001 uses the base unchanged as the address. It writes back base+1 or base+2 and costs 2 or 3 cycles.
- R6: Low nibble 0010 or 0011 subtracts 1 or 2 from the base. The result is both the address and the write-back value, at a cost of 2 or 3 cycles.
- R7: When the opcode is 0x30, 0x31, 0x32 or 0x33, the target register is X, Y, S or U respectively. If that target equals the base register, the direct post-increment forms give no write-back. The pre-decrement forms are not affected.
- R8: With bit 7 and bit 4 set, the computed address is issued on `mem_addr` with `mem_req` held until `mem_ready`. The word read becomes the effective address, and the cost is the direct cost plus 3.
- R9: Descriptor 0x9F (any value in bits 6-5) fetches a 16-bit absolute address and reads the pointer there. It costs 5 cycles and gives no write-back.
- R10: Indirect step-by-1 forms, the low nibbles 0111, 1010 and 1110, and the direct form of 1111 set `illegal`. They report address 0, 0 cycles and no write-back, with no fetch and no memory read, and `done` rises in the cycle after `start`.
- R11: `fetch_req` stays high until a byte is taken on a rising edge with `fetch_ready` high. The unit never requests a byte and a word in the same cycle.
- R12: After reset, `done`, `fetch_req`, `mem_req`, `wb_en` and `illegal` are low, and `ea` and `extra_cycles` are zero.
- R13: `done` is a one-cycle pulse. The result outputs keep their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one address computation (unit idle) |
| postbyte | input | 8 | Addressing descriptor |
| opcode | input | 8 | Opcode of the instruction being decoded |
| reg_x | input | 16 | X register value |
| reg_y | input | 16 | Y register value |
| reg_u | input | 16 | U register value |
| reg_s | input | 16 | S register value |
| reg_pc | input | 16 | Program counter, pointing just past the descriptor |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| fetch_req | output | 1 | Request for the next instruction-stream byte |
| fetch_ready | input | 1 | Byte on `fetch_data` is valid and taken |
| fetch_data | input | 8 | Instruction-stream byte |
| mem_req | output | 1 | Pointer word read request |
| mem_addr | output | 16 | Pointer word address |
| mem_ready | input | 1 | Word on `mem_data` is valid |
| mem_data | input | 16 | Pointer word |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base register must be updated |
| wb_sel | output | 2 | Base register code for the update |
| wb_value | output | 16 | New base register value |
| extra_cycles | output | 4 | Extra cycles charged for the mode |
| illegal | output | 1 | Descriptor has no defined meaning |
| pc_next | output | 16 | Program counter after offset bytes |

## Verification
Results are due one edge after `start` when nothing is fetched. Each fetched byte adds one edge in which `fetch_ready` is high, and the indirect read adds one edge in which `mem_ready` is high. The bench model tracks that phase itself: at every falling edge it predicts whether `fetch_req`, `mem_req` or `done` is high, and checks the address offered for the pointer read. The result fields are compared only at the falling edge where the model expects `done`, and again one cycle later to confirm they hold. Stalled handshakes, which withhold ready on alternate cycles, move the due cycle, and the model moves with it.

// File: rtl/idx_pkg.sv
// Package: shared widths, mode kinds and the decoded-descriptor record for
// the indexed effective-address unit. Assumes a 16-bit address space and an
// 8-bit instruction stream.
package idx_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CYC_W  = 4;
    localparam int NB_W   = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CYC_W-1:0]  cyc_t;
    typedef logic [NB_W-1:0]   nb_t;

    // K_BAD is encoded zero so a cleared record reads as "no mode".
    typedef enum logic [3:0] {
        K_BAD, K_C5, K_NONE, K_ACC_A, K_ACC_B, K_ACC_D, K_C8, K_C16,
        K_PC8, K_PC16, K_INC1, K_INC2, K_DEC1, K_DEC2, K_EXT
    } kind_t;

    typedef struct packed {
        kind_t kind;
        logic  ind;
        nb_t   nbytes;
        cyc_t  cyc;
        logic  wb;
        logic  bad;
    } dec_t;

    // Sign-extend a byte to an address.
    function automatic addr_t sx8(input logic [BYTE_W-1:0] v);
        return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
    endfunction

    // Sign-extend the embedded 5-bit constant to an address.
    function automatic addr_t sx5(input logic [4:0] v);
        return {{(ADDR_W-5){v[4]}}, v};
    endfunction
endpackage

// File: rtl/idx_decode.sv
// Module: idx_decode
// Combinational decode of the addressing descriptor into a mode kind, the
// number of offset bytes to fetch, the indirect flag, the extra-cycle cost,
// whether a base write-back is due, and an illegal flag.
// Assumes: opcode 0x30..0x33 are the load-effective-address forms whose
// targets are X, Y, S, U in that order.
module idx_decode
    import idx_pkg::*;
(
    input  logic [7:0] postbyte,
    input  logic [7:0] opcode,
    output dec_t       dec
);
    logic [1:0] lea_tgt;
    logic       is_lea;
    logic       self_step;

    // Map an address-load opcode onto the base register code it targets.
    always_comb begin
        is_lea  = (opcode[7:2] == 6'b001100);
        lea_tgt = {opcode[1], opcode[1] ^ opcode[0]};
    end

    // Translate the descriptor into a decoded record.
    always_comb begin
        dec = '0;
        if (!postbyte[7]) begin
            dec.kind = K_C5;
            dec.cyc  = cyc_t'(1);
        end else begin
            dec.ind = postbyte[4];
            unique case (postbyte[3:0])
                4'h0: begin dec.kind = K_INC1;  dec.cyc = cyc_t'(2); end
                4'h1: begin dec.kind = K_INC2;  dec.cyc = cyc_t'(3); end
                4'h2: begin dec.kind = K_DEC1;  dec.cyc = cyc_t'(2); end
                4'h3: begin dec.kind = K_DEC2;  dec.cyc = cyc_t'(3); end
                4'h4: begin dec.kind = K_NONE;  dec.cyc = cyc_t'(0); end
                4'h5: begin dec.kind = K_ACC_B; dec.cyc = cyc_t'(1); end
                4'h6: begin dec.kind = K_ACC_A; dec.cyc = cyc_t'(1); end
                4'h8: begin dec.kind = K_C8;  dec.nbytes = nb_t'(1); dec.cyc = cyc_t'(1); end
                4'h9: begin dec.kind = K_C16; dec.nbytes = nb_t'(2); dec.cyc = cyc_t'(4); end
                4'hB: begin dec.kind = K_ACC_D; dec.cyc = cyc_t'(4); end
                4'hC: begin dec.kind = K_PC8;  dec.nbytes = nb_t'(1); dec.cyc = cyc_t'(1); end
                4'hD: begin dec.kind = K_PC16; dec.nbytes = nb_t'(2); dec.cyc = cyc_t'(5); end
                4'hF: begin dec.kind = K_EXT;  dec.nbytes = nb_t'(2); dec.cyc = cyc_t'(5); end
                default: dec.kind = K_BAD;
            endcase
        end

        dec.bad = (dec.kind == K_BAD)
                || (dec.ind && (dec.kind == K_INC1 || dec.kind == K_DEC1))
                || (!dec.ind && dec.kind == K_EXT);

        self_step = !dec.ind && is_lea && (lea_tgt == postbyte[6:5])
                    && (dec.kind == K_INC1 || dec.kind == K_INC2);

        if (dec.bad) begin
            dec     = '0;
            dec.bad = 1'b1;
        end else begin
            if (dec.ind && dec.kind != K_EXT)
                dec.cyc = dec.cyc + cyc_t'(3);
            dec.wb = (dec.kind == K_INC1 || dec.kind == K_INC2 ||
                      dec.kind == K_DEC1 || dec.kind == K_DEC2) && !self_step;
        end
    end
endmodule

// File: rtl/idx_addr_calc.sv
// Module: idx_addr_calc
// Combinational address arithmetic: selects the base register, forms the
// offset for the decoded kind, and returns the address, the stepped base
// value and the program counter advanced past the offset bytes.
// Assumes off_word already holds the fetched offset (low byte in [7:0]).
module idx_addr_calc
    import idx_pkg::*;
(
    input  kind_t       kind,
    input  nb_t         nbytes,
    input  logic [1:0]  base_sel,
    input  logic [4:0]  off5,
    input  addr_t       reg_x,
    input  addr_t       reg_y,
    input  addr_t       reg_u,
    input  addr_t       reg_s,
    input  addr_t       reg_pc,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    input  addr_t       off_word,
    output addr_t       addr,
    output addr_t       wb_value,
    output addr_t       pc_adv
);
    addr_t bank [4];
    addr_t base;

    // Collect the index registers in descriptor code order.
    generate
        for (genvar g = 0; g < 4; g++) begin : g_bank
            if (g == 0)      assign bank[g] = reg_x;
            else if (g == 1) assign bank[g] = reg_y;
            else if (g == 2) assign bank[g] = reg_u;
            else             assign bank[g] = reg_s;
        end
    endgenerate

    assign base   = bank[base_sel];
    assign pc_adv = reg_pc + addr_t'(nbytes);

    // Form the address and the stepped base for the decoded kind.
    always_comb begin
        addr     = '0;
        wb_value = base;
        unique case (kind)
            K_C5:    addr = base + sx5(off5);
            K_NONE:  addr = base;
            K_ACC_A: addr = base + sx8(acc_a);
            K_ACC_B: addr = base + sx8(acc_b);
            K_ACC_D: addr = base + {acc_a, acc_b};
            K_C8:    addr = base + sx8(off_word[7:0]);
            K_C16:   addr = base + off_word;
            K_PC8:   addr = pc_adv + sx8(off_word[7:0]);
            K_PC16:  addr = pc_adv + off_word;
            K_INC1:  begin addr = base; wb_value = base + addr_t'(1); end
            K_INC2:  begin addr = base; wb_value = base + addr_t'(2); end
            K_DEC1:  begin addr = base - addr_t'(1); wb_value = addr; end
            K_DEC2:  begin addr = base - addr_t'(2); wb_value = addr; end
            K_EXT:   addr = off_word;
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/idx_seq.sv
// Module: idx_seq
// Sequencer: collects offset bytes over the fetch handshake, performs the
// optional pointer read, and registers all results with a one-cycle done.
// Assumes start is only raised while idle and the decoded inputs stay
// stable until done.
module idx_seq
    import idx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  nb_t         nbytes,
    input  logic        ind,
    input  cyc_t        cyc,
    input  logic        wb,
    input  logic        bad,
    input  logic [1:0]  base_sel,
    input  addr_t       calc_addr,
    input  addr_t       calc_wb,
    input  addr_t       calc_pc,
    output addr_t       off_word,
    output logic        fetch_req,
    input  logic        fetch_ready,
    input  logic [7:0]  fetch_data,
    output logic        mem_req,
    output addr_t       mem_addr,
    input  logic        mem_ready,
    input  addr_t       mem_data,
    output logic        done,
    output addr_t       ea,
    output logic        wb_en,
    output logic [1:0]  wb_sel,
    output addr_t       wb_value,
    output cyc_t        extra_cycles,
    output logic        illegal,
    output addr_t       pc_next
);
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_IND} st_t;

    st_t   state;
    nb_t   left;
    addr_t op_q;
    logic  finish;

    assign fetch_req = (state == ST_FETCH);
    assign mem_req   = (state == ST_IND);
    assign mem_addr  = ea;

    // Offset as seen by the arithmetic, including the byte arriving now.
    assign off_word = (state == ST_FETCH) ? {op_q[ADDR_W-BYTE_W-1:0], fetch_data} : op_q;

    // The address is complete when no bytes are needed or the last one lands.
    always_comb begin
        finish = ((state == ST_IDLE) && start && (nbytes == '0))
              || ((state == ST_FETCH) && fetch_ready && (left == nb_t'(1)));
    end

    // Main control and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            left         <= '0;
            op_q         <= '0;
            done         <= 1'b0;
            ea           <= '0;
            wb_en        <= 1'b0;
            wb_sel       <= '0;
            wb_value     <= '0;
            extra_cycles <= '0;
            illegal      <= 1'b0;
            pc_next      <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && nbytes != '0) begin
                        left  <= nbytes;
                        op_q  <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_ready) begin
                        op_q <= off_word;
                        left <= left - nb_t'(1);
                    end
                end
                ST_IND: begin
                    if (mem_ready) begin
                        ea    <= mem_data;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (finish) begin
                ea           <= calc_addr;
                wb_en        <= wb;
                wb_sel       <= base_sel;
                wb_value     <= calc_wb;
                extra_cycles <= cyc;
                illegal      <= bad;
                pc_next      <= calc_pc;
                if (ind) begin
                    state <= ST_IND;
                end else begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            end
        end
    end

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ready |=> fetch_req);                      // R11
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && mem_req));                                      // R11
    AST_PTR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr));       // R8
    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done && illegal |-> !wb_en && extra_cycles == '0);             // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);                                     // R13
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> $stable(ea) && $stable(extra_cycles));      // R13
endmodule

// File: rtl/idx_ea_unit.sv
// Module: idx_ea_unit (top)
// Indexed-mode effective-address unit: wires decode, arithmetic and the
// sequencer. Assumes all request inputs are held from start until done.
module idx_ea_unit
    import idx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  postbyte,
    input  logic [7:0]  opcode,
    input  logic [15:0] reg_x,
    input  logic [15:0] reg_y,
    input  logic [15:0] reg_u,
    input  logic [15:0] reg_s,
    input  logic [15:0] reg_pc,
    input  logic [7:0]  acc_a,
    input  logic [7:0]  acc_b,
    output logic        fetch_req,
    input  logic        fetch_ready,
    input  logic [7:0]  fetch_data,
    output logic        mem_req,
    output logic [15:0] mem_addr,
    input  logic        mem_ready,
    input  logic [15:0] mem_data,
    output logic        done,
    output logic [15:0] ea,
    output logic        wb_en,
    output logic [1:0]  wb_sel,
    output logic [15:0] wb_value,
    output logic [3:0]  extra_cycles,
    output logic        illegal,
    output logic [15:0] pc_next
);
    dec_t  dec;
    addr_t calc_addr;
    addr_t calc_wb;
    addr_t calc_pc;
    addr_t off_word;

    idx_decode u_dec (
        .postbyte (postbyte),
        .opcode   (opcode),
        .dec      (dec)
    );

    idx_addr_calc u_calc (
        .kind     (dec.kind),
        .nbytes   (dec.nbytes),
        .base_sel (postbyte[6:5]),
        .off5     (postbyte[4:0]),
        .reg_x    (reg_x),
        .reg_y    (reg_y),
        .reg_u    (reg_u),
        .reg_s    (reg_s),
        .reg_pc   (reg_pc),
        .acc_a    (acc_a),
        .acc_b    (acc_b),
        .off_word (off_word),
        .addr     (calc_addr),
        .wb_value (calc_wb),
        .pc_adv   (calc_pc)
    );

    idx_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .nbytes       (dec.nbytes),
        .ind          (dec.ind),
        .cyc          (dec.cyc),
        .wb           (dec.wb),
        .bad          (dec.bad),
        .base_sel     (postbyte[6:5]),
        .calc_addr    (calc_addr),
        .calc_wb      (calc_wb),
        .calc_pc      (calc_pc),
        .off_word     (off_word),
        .fetch_req    (fetch_req),
        .fetch_ready  (fetch_ready),
        .fetch_data   (fetch_data),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_ready    (mem_ready),
        .mem_data     (mem_data),
        .done         (done),
        .ea           (ea),
        .wb_en        (wb_en),
        .wb_sel       (wb_sel),
        .wb_value     (wb_value),
        .extra_cycles (extra_cycles),
        .illegal      (illegal),
        .pc_next      (pc_next)
    );

    AST_SMALL_OFF_COST: assert property (@(posedge clk) disable iff (!rst_n)
        done && !postbyte[7] |-> extra_cycles == 4'd1 && !illegal);    // R1
    AST_EXT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        done && postbyte[7] && postbyte[4:0] == 5'h1F |-> !wb_en);     // R9
    AST_BAD_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        done && illegal |-> $past(!fetch_req && !mem_req));            // R10
endmodule

// File: tb/idx_ea_unit_tb_top.sv
module idx_ea_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = 8'h00;
    logic [7:0]  opcode = 8'h12;
    logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_u = 16'h3000;
    logic [15:0] reg_s = 16'h4000, reg_pc = 16'h5000;
    logic [7:0]  acc_a = 8'h00, acc_b = 8'h00;
    logic        fetch_ready = 1'b0;
    logic [7:0]  fetch_data = 8'h00;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_data = 16'h0000;
    logic        fetch_req, mem_req, done, wb_en, illegal;
    logic [15:0] mem_addr, ea, wb_value, pc_next;
    logic [1:0]  wb_sel;
    logic [3:0]  extra_cycles;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    idx_ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .opcode(opcode), .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u),
        .reg_s(reg_s), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
        .fetch_req(fetch_req), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_data(mem_data), .done(done), .ea(ea), .wb_en(wb_en),
        .wb_sel(wb_sel), .wb_value(wb_value), .extra_cycles(extra_cycles),
        .illegal(illegal), .pc_next(pc_next)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            fails++;
            checks++;
            $display("FAIL R13 watchdog actual=%0d expected=%0d", cycles, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // One computation, modelled phase by phase and compared every cycle.
    task automatic run(input string tag, input logic [7:0] pb, input logic [7:0] opc,
                       input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] off, input logic [15:0] ptr, input bit stall);
        logic [15:0] base, addr, wbv, exp_ea;
        int nb, cyc, left, phase, k;
        bit ind, bad, wbe, rdy;
        logic [1:0] tgt;
        base = (pb[6:5] == 2'd0) ? reg_x : (pb[6:5] == 2'd1) ? reg_y :
               (pb[6:5] == 2'd2) ? reg_u : reg_s;
        nb = 0; cyc = 0; ind = 0; bad = 0; wbe = 0; wbv = 0; addr = 0;
        if (!pb[7]) begin
            addr = base + {{11{pb[4]}}, pb[4:0]}; cyc = 1;
        end else begin
            ind = pb[4];
            case (pb[3:0])
                4'h0: begin bad = ind; addr = base; wbe = 1; wbv = base + 16'd1; cyc = 2; end
                4'h1: begin addr = base; wbe = 1; wbv = base + 16'd2; cyc = 3; end
                4'h2: begin bad = ind; addr = base - 16'd1; wbe = 1; wbv = addr; cyc = 2; end
                4'h3: begin addr = base - 16'd2; wbe = 1; wbv = addr; cyc = 3; end
                4'h4: begin addr = base; cyc = 0; end
                4'h5: begin addr = base + {{8{b[7]}}, b}; cyc = 1; end
                4'h6: begin addr = base + {{8{a[7]}}, a}; cyc = 1; end
                4'h8: begin nb = 1; addr = base + {{8{off[7]}}, off[7:0]}; cyc = 1; end
                4'h9: begin nb = 2; addr = base + off; cyc = 4; end
                4'hB: begin addr = base + {a, b}; cyc = 4; end
                4'hC: begin nb = 1; addr = reg_pc + 16'd1 + {{8{off[7]}}, off[7:0]}; cyc = 1; end
                4'hD: begin nb = 2; addr = reg_pc + 16'd2 + off; cyc = 5; end
                4'hF: begin bad = !ind; nb = 2; addr = off; cyc = 2; end
                default: bad = 1;
            endcase
            if (ind) cyc += 3;
            tgt = {opc[1], opc[1] ^ opc[0]};
            if (!ind && pb[3:1] == 3'b000 && opc >= 8'h30 && opc <= 8'h33 && tgt == pb[6:5])
                wbe = 0;
        end
        if (bad) begin nb = 0; cyc = 0; ind = 0; wbe = 0; addr = 0; end
        exp_ea = ind ? ptr : addr;

        @(negedge clk);
        postbyte = pb; opcode = opc; acc_a = a; acc_b = b; mem_data = ptr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        left = nb;
        phase = (nb > 0) ? 1 : (ind ? 2 : 3);
        k = 0;
        while (1) begin
            chk(fetch_req == (phase == 1), tag, "fetch_req", fetch_req, phase == 1);
            chk(mem_req == (phase == 2), tag, "mem_req", mem_req, phase == 2);
            chk(done == (phase == 3), tag, "done", done, phase == 3);
            if (phase == 2) chk(mem_addr == addr, tag, "mem_addr", mem_addr, addr);
            if (phase == 3 || k > 40) break;
            rdy = stall ? (k % 2 == 1) : 1'b1;
            k++;
            fetch_ready = (phase == 1) && rdy;
            mem_ready   = (phase == 2) && rdy;
            fetch_data  = (nb == 2 && left == 2) ? off[15:8] : off[7:0];
            if (phase == 1 && rdy) begin
                left--;
                if (left == 0) phase = ind ? 2 : 3;
            end else if (phase == 2 && rdy) begin
                phase = 3;
            end
            @(negedge clk);
        end
        fetch_ready = 1'b0; mem_ready = 1'b0;
        chk(ea == exp_ea, tag, "ea", ea, exp_ea);
        chk(extra_cycles == cyc[3:0], tag, "extra_cycles", extra_cycles, cyc);
        chk(illegal == bad, tag, "illegal", illegal, bad);
        chk(wb_en == wbe, tag, "wb_en", wb_en, wbe);
        if (wbe) begin
            chk(wb_sel == pb[6:5], tag, "wb_sel", wb_sel, pb[6:5]);
            chk(wb_value == wbv, tag, "wb_value", wb_value, wbv);
        end
        chk(pc_next == reg_pc + 16'(nb), tag, "pc_next", pc_next, reg_pc + 16'(nb));
        @(negedge clk);
        chk(done == 1'b0, "R13", "done pulse", done, 0);
        chk(ea == exp_ea, "R13", "ea hold", ea, exp_ea);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk(!done && !fetch_req && !mem_req, "R12", "ctl idle", {done, fetch_req, mem_req}, 0);
        chk(!wb_en && !illegal, "R12", "flags", {wb_en, illegal}, 0);
        chk(ea == 0 && extra_cycles == 0, "R12", "ea/cyc", ea, 0);

        run("R1", 8'h05, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R1", 8'h3F, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R1", 8'h50, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R1", 8'h6F, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R2", 8'h88, 8'h12, 8'h00, 8'h00, 16'h0080, 16'h0, 1);
        run("R2", 8'hA9, 8'h12, 8'h00, 8'h00, 16'h1234, 16'h0, 0);
        run("R2", 8'hC9, 8'h12, 8'h00, 8'h00, 16'hFFF0, 16'h0, 1);
        run("R3", 8'h84, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R3", 8'h86, 8'h12, 8'hF0, 8'h00, 16'h0, 16'h0, 0);
        run("R3", 8'hC5, 8'h12, 8'h00, 8'h7F, 16'h0, 16'h0, 0);
        run("R3", 8'hEB, 8'h12, 8'h81, 8'h02, 16'h0, 16'h0, 0);
        run("R4", 8'h8C, 8'h12, 8'h00, 8'h00, 16'h00FE, 16'h0, 0);
        run("R4", 8'h8D, 8'h12, 8'h00, 8'h00, 16'h8000, 16'h0, 1);
        run("R5", 8'h80, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R5", 8'hA1, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R6", 8'h82, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R6", 8'hE3, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R7", 8'h80, 8'h30, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R7", 8'hE1, 8'h32, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R7", 8'hC1, 8'h33, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R7", 8'hE1, 8'h33, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R7", 8'hA2, 8'h31, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R8", 8'h94, 8'h12, 8'h00, 8'h00, 16'h0, 16'hBEEF, 0);
        run("R8", 8'h98, 8'h12, 8'h00, 8'h00, 16'h00F8, 16'hCAFE, 1);
        run("R8", 8'hB9, 8'h12, 8'h00, 8'h00, 16'h0102, 16'h1357, 0);
        run("R8", 8'h91, 8'h30, 8'h00, 8'h00, 16'h0, 16'h2468, 0);
        run("R8", 8'hF3, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0A0B, 1);
        run("R8", 8'h9C, 8'h12, 8'h00, 8'h00, 16'h0010, 16'h7777, 0);
        run("R8", 8'h9D, 8'h12, 8'h00, 8'h00, 16'hFF00, 16'h8888, 1);
        run("R8", 8'h96, 8'h12, 8'h80, 8'h00, 16'h0, 16'h4321, 0);
        run("R9", 8'h9F, 8'h12, 8'h00, 8'h00, 16'hC000, 16'hD00D, 0);
        run("R9", 8'h9F, 8'h12, 8'h00, 8'h00, 16'h0042, 16'h1111, 1);
        run("R10", 8'h90, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R10", 8'hB2, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R10", 8'h87, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R10", 8'h8A, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R10", 8'hAE, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R10", 8'h8F, 8'h12, 8'h00, 8'h00, 16'h0, 16'h0, 0);
        run("R11", 8'hA9, 8'h12, 8'h00, 8'h00, 16'h8001, 16'h0, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule